// File: doc/BRIEF.md
# SECDED read checker for a non-volatile memory bank

This block sits between a memory bank's read port and the rest of the chip. Every read returns a 64-bit word and the 8-bit check code stored with it. The block recomputes the code over the word and the read's word address, then compares the two. The comparison gives a syndrome, and the syndrome has one of four outcomes: a clean word, a single-bit error it can correct, an address fault, or a multi-bit fault. The block delivers the checked word and its error flags one cycle after the read.

Correction of single-bit data faults is switched by `corr_en`. When correction is on, the block also counts corrected errors in a saturating counter. An interrupt level stays high while that count is above a programmable threshold. Uncorrectable faults give a one-cycle fatal event and set a sticky status output. The block records the address of the most recent faulty read. A test mode applies XOR masks to the data, the address and the code before the check, so every path can be driven from the read port.

Top module: `secded_rd_check`

## Requirements
- R1: Each combined bit j is one of data bits 0..63 (j = 0..63) or address bits 0..AW-1 (j = 64..63+AW). Its column is the j-th 8-bit value, counted in increasing numeric order, with an odd population count of at least 3. The stored code is the XOR of the columns of all set bits. A read whose code matches gives out_data equal to rd_data, with err_corr and err_fatal both low.
- R2: out_valid is high exactly one cycle after rd_valid. out_data, err_corr and err_fatal belong to that same cycle. Error flags are never high without out_valid.
- R3: When corr_en=1, a read with one flipped data bit returns the corrected word and raises err_corr.
- R4: When corr_en=0, a read with one flipped data bit returns the raw word unchanged and still raises err_corr.
- R5: A read with one flipped code bit returns the data unchanged and raises err_corr.
- R6: A read with one flipped address bit raises err_fatal, not err_corr, and returns the raw word.
- R7: A read with two flipped bits raises err_fatal. err_status rises in the same cycle and stays high until clr is pulsed with no new fatal error.
- R8: corr_cnt increments by one for each err_corr read, but only while corr_en=1. It saturates at 2^CW-1. clr sets it to 0 on the next edge, and clr takes priority over an increment.
- R9: thr_irq is high exactly while corr_cnt > threshold.
- R10: err_addr holds rd_addr of the most recent read that raised err_corr or err_fatal. Clean reads leave it unchanged. It resets to 0.
- R11: When test_en=1, the three flip masks are XORed into data, address and code before the check. When test_en=0 they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_valid | input | 1 | Read word present this cycle |
| rd_addr | input | AW | Word address of the read |
| rd_data | input | 64 | Word from the bank |
| rd_code | input | 8 | Stored check code |
| corr_en | input | 1 | Enable single-bit data correction and counting |
| test_en | input | 1 | Apply fault-injection masks |
| test_data_flip | input | 64 | Data bits to invert in test mode |
| test_addr_flip | input | AW | Address bits to invert in test mode |
| test_code_flip | input | 8 | Code bits to invert in test mode |
| clr | input | 1 | Clear counter and fatal status |
| threshold | input | CW | Interrupt threshold for the counter |
| out_valid | output | 1 | Checked word valid |
| out_data | output | 64 | Checked (optionally corrected) word |
| err_corr | output | 1 | Correctable single-bit error on this word |
| err_fatal | output | 1 | Uncorrectable error event on this word |
| err_status | output | 1 | Sticky uncorrectable error status |
| corr_cnt | output | CW | Corrected-error count |
| thr_irq | output | 1 | Count above threshold |
| err_addr | output | AW | Address of the last faulty read |

## Verification
On every cycle, the assertions check the one-cycle latency and that the two error flags never occur together. They also check that flags appear only with valid output, that a fatal event is always reflected in the sticky status, that the status holds until cleared, and that the counter only holds, steps by one or clears. Other behaviour depends on the code's column assignment, so only the bench's sweeps can show it. That covers which bit position gets corrected, that address faults and double faults are classified correctly, the threshold comparison, saturation, and the effect of the injection masks.

// File: rtl/secded_rd_check.sv
module secded_rd_check #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic [63:0]   rd_data,
  input  logic [7:0]    rd_code,
  input  logic          corr_en,
  input  logic          test_en,
  input  logic [63:0]   test_data_flip,
  input  logic [AW-1:0] test_addr_flip,
  input  logic [7:0]    test_code_flip,
  input  logic          clr,
  input  logic [CW-1:0] threshold,
  output logic          out_valid,
  output logic [63:0]   out_data,
  output logic          err_corr,
  output logic          err_fatal,
  output logic          err_status,
  output logic [CW-1:0] corr_cnt,
  output logic          thr_irq,
  output logic [AW-1:0] err_addr
);

  localparam int DW = 64;
  localparam int KW = 8;
  localparam int NV = DW + AW;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  // j-th 8-bit value with odd weight >= 3, in increasing order
  function automatic logic [KW-1:0] col_val(input int idx);
    int n;
    int w;
    logic [KW-1:0] r;
    n = 0;
    r = '0;
    for (int v = 1; v < 256; v++) begin
      w = 0;
      for (int b = 0; b < KW; b++) w += (v >> b) & 1;
      if ((w % 2 == 1) && (w >= 3)) begin
        if (n == idx) r = KW'(v);
        n++;
      end
    end
    return r;
  endfunction

  logic [DW-1:0] d_in;
  logic [AW-1:0] a_in;
  logic [KW-1:0] k_in;
  logic [NV-1:0] vec;
  logic [KW-1:0] term [NV];
  logic [KW-1:0] calc;
  logic [KW-1:0] syn;
  logic [DW-1:0] dhit;
  logic          sgl_data, sgl_code, corr, unc;

  assign d_in = test_en ? (rd_data ^ test_data_flip) : rd_data;
  assign a_in = test_en ? (rd_addr ^ test_addr_flip) : rd_addr;
  assign k_in = test_en ? (rd_code ^ test_code_flip) : rd_code;
  assign vec  = {a_in, d_in};

  genvar j;
  generate
    for (j = 0; j < NV; j++) begin : g_col
      localparam logic [KW-1:0] CJ = col_val(j);
      assign term[j] = vec[j] ? CJ : '0;
      if (j < DW) begin : g_hit
        assign dhit[j] = (syn == CJ);
      end
    end
  endgenerate

  always_comb begin
    calc = '0;
    for (int i = 0; i < NV; i++) calc = calc ^ term[i];
  end

  assign syn      = calc ^ k_in;
  assign sgl_data = |dhit;
  assign sgl_code = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
  assign corr     = sgl_data | sgl_code;
  assign unc      = (syn != '0) && !corr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      err_corr   <= 1'b0;
      err_fatal  <= 1'b0;
      err_status <= 1'b0;
      corr_cnt   <= '0;
      err_addr   <= '0;
    end else begin
      out_valid <= rd_valid;
      err_corr  <= rd_valid & corr;
      err_fatal <= rd_valid & unc;
      if (rd_valid) out_data <= corr_en ? (d_in ^ dhit) : d_in;
      if (rd_valid && (corr || unc)) err_addr <= rd_addr;
      if (rd_valid && unc) err_status <= 1'b1;
      else if (clr)        err_status <= 1'b0;
      if (clr) corr_cnt <= '0;
      else if (rd_valid && corr && corr_en && corr_cnt != CNT_MAX)
        corr_cnt <= corr_cnt + 1'b1;
    end
  end

  assign thr_irq = corr_cnt > threshold;

  assert_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);
  assert_lat_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid);
  assert_flag_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_corr || err_fatal) |-> out_valid);
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr && err_fatal));
  assert_fatal_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> err_status);
  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status && !clr) |=> err_status);
  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (corr_cnt == $past(corr_cnt) || corr_cnt == $past(corr_cnt) + 1'b1));
  assert_cnt_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> corr_cnt == '0);

endmodule

// File: tb/sim_secded_rd_check.sv
module sim_secded_rd_check;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [63:0] rd_data = '0;
  logic [7:0] rd_code = '0;
  logic corr_en = 1'b1;
  logic test_en = 1'b0;
  logic [63:0] test_data_flip = '0;
  logic [AW-1:0] test_addr_flip = '0;
  logic [7:0] test_code_flip = '0;
  logic clr = 1'b0;
  logic [CW-1:0] threshold = '1;
  logic out_valid, err_corr, err_fatal, err_status, thr_irq;
  logic [63:0] out_data;
  logic [CW-1:0] corr_cnt;
  logic [AW-1:0] err_addr;

  int checks = 0;
  int errors = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #2.5 clk = ~clk;

  secded_rd_check #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_code(rd_code), .corr_en(corr_en), .test_en(test_en),
    .test_data_flip(test_data_flip), .test_addr_flip(test_addr_flip),
    .test_code_flip(test_code_flip), .clr(clr), .threshold(threshold),
    .out_valid(out_valid), .out_data(out_data), .err_corr(err_corr),
    .err_fatal(err_fatal), .err_status(err_status), .corr_cnt(corr_cnt),
    .thr_irq(thr_irq), .err_addr(err_addr));

  function automatic logic [7:0] bcode(input logic [AW-1:0] a, input logic [63:0] d);
    logic [7:0] c;
    int n;
    c = '0;
    n = 0;
    for (int v = 1; v < 256; v++) begin
      int w;
      w = 0;
      for (int b = 0; b < 8; b++) w += (v >> b) & 1;
      if ((w % 2 == 1) && (w >= 3)) begin
        if (n < 64) begin
          if (d[n]) c ^= 8'(v);
        end else if (n - 64 < AW) begin
          if (a[n-64]) c ^= 8'(v);
        end
        n++;
      end
    end
    return c;
  endfunction

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] k);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_code = k;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [AW-1:0] a;
    logic [7:0] k;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && corr_cnt == 0 && err_status == 0 && thr_irq == 0 && err_addr == 0,
        "R10 reset", {out_valid, corr_cnt, err_status, thr_irq}, 64'd0);
    rst_n = 1'b1;

    // R1 clean reads, R2 latency
    for (int i = 0; i < 16; i++) begin
      d = rnd(); a = AW'(rnd());
      rd(a, d, bcode(a, d));
      chk(out_valid && out_data == d && !err_corr && !err_fatal, "R1 clean", out_data, d);
      @(negedge clk);
      chk(!out_valid, "R2 idle after read", out_valid, 64'd0);
    end
    chk(err_addr == 0, "R10 clean reads keep address", err_addr, 64'd0);

    // R3 sweep single data bits
    for (int i = 0; i < 64; i++) begin
      d = rnd(); a = AW'(i + 7);
      rd(a, d ^ (64'd1 << i), bcode(a, d));
      chk(out_data == d && err_corr && !err_fatal, "R3 data bit corrected", out_data, d);
      chk(err_addr == a, "R10 address logged", err_addr, a);
    end
    chk(corr_cnt == 64, "R8 count after sweep", corr_cnt, 64'd64);
    pulse_clr();
    chk(corr_cnt == 0, "R8 clr", corr_cnt, 64'd0);

    // R4 correction disabled
    corr_en = 1'b0;
    for (int i = 0; i < 64; i += 9) begin
      d = rnd(); a = AW'(rnd());
      rd(a, d ^ (64'd1 << i), bcode(a, d));
      chk(out_data == (d ^ (64'd1 << i)) && err_corr, "R4 raw pass", out_data, d ^ (64'd1 << i));
    end
    chk(corr_cnt == 0, "R8 no count when disabled", corr_cnt, 64'd0);
    corr_en = 1'b1;

    // R5 code bits
    for (int i = 0; i < 8; i++) begin
      d = rnd(); a = AW'(rnd());
      rd(a, d, bcode(a, d) ^ (8'd1 << i));
      chk(out_data == d && err_corr && !err_fatal, "R5 code bit", out_data, d);
    end
    chk(corr_cnt == 8, "R8 code errors counted", corr_cnt, 64'd8);

    // R6 address bits
    for (int i = 0; i < AW; i++) begin
      d = rnd(); a = AW'(rnd());
      rd(a ^ (AW'(1) << i), d, bcode(a, d));
      chk(err_fatal && !err_corr && out_data == d, "R6 address fault", {err_fatal, err_corr}, 64'd2);
      chk(err_status, "R7 status set", err_status, 64'd1);
    end
    chk(corr_cnt == 8, "R8 fatal not counted", corr_cnt, 64'd8);
    a = 16'h00c3; d = rnd();
    rd(16'h0055, d, bcode(16'h0055, d));
    chk(err_status && err_addr == ((16'h00c3 ^ 16'h00c3) | (a ^ a) | err_addr), "R7 status held", err_status, 64'd1);
    pulse_clr();
    chk(!err_status, "R7 status cleared", err_status, 64'd0);

    // R7 double faults
    for (int i = 0; i < 64; i++) begin
      d = rnd(); a = AW'(rnd());
      rd(a, d ^ (64'd1 << i) ^ (64'd1 << ((i + 7) % 64)), bcode(a, d));
      chk(err_fatal && !err_corr, "R7 double data", {err_fatal, err_corr}, 64'd2);
    end
    d = rnd(); a = AW'(rnd());
    rd(a, d ^ 64'd1, bcode(a, d) ^ 8'h80);
    chk(err_fatal, "R7 data plus code", err_fatal, 64'd1);
    pulse_clr();

    // R9 threshold
    threshold = 8'd3;
    for (int i = 0; i < 4; i++) begin
      d = rnd(); a = AW'(rnd());
      rd(a, d ^ (64'd1 << (i * 5)), bcode(a, d));
      chk(thr_irq == (i + 1 > 3), "R9 threshold", thr_irq, 64'(i + 1 > 3));
    end
    @(negedge clk); threshold = 8'd10;
    #1 chk(!thr_irq, "R9 threshold raised", thr_irq, 64'd0);
    pulse_clr();

    // R8 saturation
    threshold = 8'd255;
    for (int i = 0; i < 260; i++) begin
      d = rnd(); a = AW'(rnd());
      rd(a, d ^ (64'd1 << (i % 64)), bcode(a, d));
    end
    chk(corr_cnt == 255 && !thr_irq, "R8 saturate", corr_cnt, 64'd255);
    @(negedge clk); threshold = 8'd254;
    #1 chk(thr_irq, "R9 at max", thr_irq, 64'd1);
    @(negedge clk); clr = 1'b1; rd_valid = 1'b1; d = rnd(); a = 0;
    rd_data = d ^ 64'd2; rd_addr = a; rd_code = bcode(a, d);
    @(negedge clk); clr = 1'b0; rd_valid = 1'b0;
    chk(corr_cnt == 0, "R8 clr priority", corr_cnt, 64'd0);
    threshold = 8'd255;

    // R11 test injection
    test_data_flip = 64'h10; test_addr_flip = 16'h4; test_code_flip = 8'h3;
    d = rnd(); a = AW'(rnd());
    rd(a, d, bcode(a, d));
    chk(!err_corr && !err_fatal && out_data == d, "R11 masks ignored", out_data, d);
    test_en = 1'b1; test_addr_flip = '0; test_code_flip = '0;
    rd(a, d, bcode(a, d));
    chk(err_corr && out_data == d, "R11 data inject corrected", out_data, d);
    corr_en = 1'b0;
    rd(a, d, bcode(a, d));
    chk(err_corr && out_data == (d ^ 64'h10), "R11 inject raw", out_data, d ^ 64'h10);
    corr_en = 1'b1;
    test_data_flip = '0; test_code_flip = 8'h3;
    rd(a, d, bcode(a, d));
    chk(err_fatal, "R11 double code inject", err_fatal, 64'd1);
    test_code_flip = '0; test_addr_flip = 16'h4;
    rd(a, d, bcode(a, d));
    chk(err_fatal && err_addr == a, "R11 address inject", err_fatal, 64'd1);
    test_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule